// File: doc/BRIEF.md
# Local Memory Wait-State Controller

This block sits on the path between a processor's SRAM-style local memory port and the memory itself, and holds the processor back with a stall signal so that memories slower than the core, or memories shared with another master, can sit on that port. Two sources of delay combine. A static 2-bit setting adds a fixed number of stall cycles to every access, for a memory that only the processor uses. A dynamic busy input, driven by the arbiter of a memory that is also shared with DMA, stalls the processor for as long as it stays high.

The processor holds its request (address, write flag, write data, byte strobes) steady while the stall is high. The block sends a single-cycle strobe to the memory in the cycle that ends the access, which is the cycle in which the stall is low. Read data from the memory is passed back in that same cycle and is forced to zero in every other cycle. The address is 20 bits (1 MB). The data path is 16 or 32 bits wide, chosen by a parameter, and the memory sees a word address.

Top module: `lmem_wait_ctrl`

## Requirements
- R1: After reset, with no request pending, `cpu_stall_o` and `mem_en_o` are low and `cpu_rdata_o` and `mem_be_o` are zero.
- R2: While `cpu_req_i` is low, `cpu_stall_o` and `mem_en_o` stay low, whatever `mem_busy_i` and `cfg_wait_i` are.
- R3: With `mem_busy_i` low, a held request with wait setting N (0 to 3) sees exactly N cycles with stall high and completes in the cycle after them, with stall low. N = 0 completes in the request's first cycle.
- R4: In any cycle with a request pending and `mem_busy_i` high, the stall is high and the fixed countdown does not advance. The countdown runs only in cycles with busy low, so the total stall equals the busy cycles plus N.
- R5: With N = 0, the request completes in the first cycle after `mem_busy_i` falls.
- R6: `mem_en_o` is high exactly in the completion cycle (request high, stall low). `mem_we_o` is high only in that cycle, and only for a write.
- R7: In a write's completion cycle, `mem_be_o` equals `cpu_be_i` (bit i enables data bits 8i+7..8i). In all other cycles it is zero.
- R8: In a read's completion cycle, `cpu_rdata_o` equals `mem_rdata_i`. In all other cycles it is zero.
- R9: `mem_addr_o` is `cpu_addr_i` shifted right by log2(DATA_W/8), for example by 2 for 32-bit data.
- R10: The wait setting is taken in the first busy-free cycle of an access. Changing `cfg_wait_i` later in the same access does not change its length.
- R11: A request withdrawn during the countdown is abandoned without a memory strobe. The next request starts from a fresh count.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until the stall drops |
| cpu_we_i | input | 1 | Write when high, read when low |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_be_i | input | DATA_W/8 | Byte strobes |
| cfg_wait_i | input | 2 | Static wait setting, 0 to 3 stall cycles |
| mem_busy_i | input | 1 | Shared-memory busy from the arbiter |
| cpu_stall_o | output | 1 | Stall back to the processor |
| cpu_rdata_o | output | DATA_W | Read data to the processor |
| mem_en_o | output | 1 | One-cycle access strobe to the memory |
| mem_we_o | output | 1 | Write enable to the memory |
| mem_addr_o | output | ADDR_W-log2(DATA_W/8) | Word address to the memory |
| mem_wdata_o | output | DATA_W | Write data to the memory |
| mem_be_o | output | DATA_W/8 | Byte enables to the memory |
| mem_rdata_i | input | DATA_W | Read data from the memory |

## Verification
Accesses are run with every wait setting while busy stays low, which measures the fixed count on its own. Busy is then raised before the count starts, in the middle of the count, and in scattered cycles, which tells a busy that pauses the count apart from one that restarts it or adds to it. The stimulus mixes reads and writes, partial strobes, and low and high addresses; reading each word back against a shadow copy tests lane routing and word addressing. Directed runs change the setting during an access, withdraw a request during the countdown, and raise busy with no request pending.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

    // Width of the static wait setting (0..3 stall cycles)
    localparam int WAIT_W = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic [WAIT_W-1:0] cnt;
    } seq_regs_t;

endpackage

// File: rtl/lmw_seq.sv
module lmw_seq
    import lmw_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              busy_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic              stall_o,
    output logic              fire_o
);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        stall_o = 1'b0;
        fire_o  = 1'b0;
        if (!req_i) begin
            // withdrawn or absent request: drop any partial count
            seq_d.state = ST_IDLE;
            seq_d.cnt   = '0;
        end else if (busy_i) begin
            // shared memory refuses this cycle; countdown frozen
            stall_o = 1'b1;
        end else begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    if (wait_i == '0) begin
                        fire_o = 1'b1;
                    end else begin
                        stall_o     = 1'b1;
                        seq_d.cnt   = wait_i - 1'b1;
                        seq_d.state = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (seq_q.cnt == '0) begin
                        fire_o      = 1'b1;
                        seq_d.state = ST_IDLE;
                    end else begin
                        stall_o   = 1'b1;
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
                default: seq_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: ST_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/lmw_lane.sv
module lmw_lane (
    input  logic       fire_i,
    input  logic       we_i,
    input  logic       be_i,
    input  logic [7:0] rd_byte_i,
    output logic       be_o,
    output logic [7:0] rd_byte_o
);

    logic rd_fire;

    always_comb begin
        rd_fire   = fire_i & ~we_i;
        be_o      = fire_i & we_i & be_i;
        rd_byte_o = rd_fire ? rd_byte_i : 8'h00;
    end

endmodule

// File: rtl/lmem_wait_ctrl.sv
module lmem_wait_ctrl
    import lmw_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8,
    localparam int OFF_W = $clog2(BE_W),
    localparam int WA_W  = ADDR_W - OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic [BE_W-1:0]   cpu_be_i,
    input  logic [WAIT_W-1:0] cfg_wait_i,
    input  logic              mem_busy_i,
    output logic              cpu_stall_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [WA_W-1:0]   mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [BE_W-1:0]   mem_be_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    logic fire;

    lmw_seq u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (cpu_req_i),
        .busy_i  (mem_busy_i),
        .wait_i  (cfg_wait_i),
        .stall_o (cpu_stall_o),
        .fire_o  (fire)
    );

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        lmw_lane u_lane (
            .fire_i    (fire),
            .we_i      (cpu_we_i),
            .be_i      (cpu_be_i[i]),
            .rd_byte_i (mem_rdata_i[8*i +: 8]),
            .be_o      (mem_be_o[i]),
            .rd_byte_o (cpu_rdata_o[8*i +: 8])
        );
    end

    always_comb begin
        mem_en_o    = fire;
        mem_we_o    = fire & cpu_we_i;
        mem_addr_o  = cpu_addr_i[ADDR_W-1:OFF_W];
        mem_wdata_o = cpu_wdata_i;
    end

endmodule

// File: rtl/lmw_checker.sv
module lmw_checker
    import lmw_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cpu_req_i,
    input logic              cpu_we_i,
    input logic              mem_busy_i,
    input logic [WAIT_W-1:0] cfg_wait_i,
    input logic              cpu_stall_o,
    input logic              mem_en_o,
    input logic              mem_we_o,
    input logic [BE_W-1:0]   mem_be_o,
    input logic [DATA_W-1:0] cpu_rdata_o
);

    logic [3:0]        nb_q;
    logic [WAIT_W-1:0] cap_q;
    logic              done;

    assign done = cpu_req_i && !cpu_stall_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            nb_q  <= '0;
            cap_q <= '0;
        end else begin
            if (cpu_req_i && !mem_busy_i && nb_q == 4'd0) cap_q <= cfg_wait_i;
            if (!cpu_req_i || !cpu_stall_o) nb_q <= '0;
            else if (!mem_busy_i && nb_q != 4'hF) nb_q <= nb_q + 4'd1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_req_i |-> (!cpu_stall_o && !mem_en_o)); // R2

    AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_req_i && mem_busy_i) |-> cpu_stall_o); // R4

    AST_WAIT_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |-> (nb_q == ((nb_q == 4'd0) ? {2'b00, cfg_wait_i} : {2'b00, cap_q}))); // R3

    AST_STROBE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_en_o == done); // R6

    AST_WE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> (mem_en_o && cpu_we_i)); // R6

    AST_BE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_we_o |-> (mem_be_o == '0)); // R7

    AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_en_o && !cpu_we_i) |-> (cpu_rdata_o == '0)); // R8

endmodule

bind lmem_wait_ctrl lmw_checker #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .mem_busy_i  (mem_busy_i),
    .cfg_wait_i  (cfg_wait_i),
    .cpu_stall_o (cpu_stall_o),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_be_o    (mem_be_o),
    .cpu_rdata_o (cpu_rdata_o)
);

// File: tb/lmem_wait_ctrl_test.sv
module lmem_wait_ctrl_test;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int WA_W   = ADDR_W - 2;

    typedef struct packed {
        logic        we;
        logic [19:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [1:0]  wt;
        logic [7:0]  busy;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        vec_t'{1'b1, 20'h00010, 32'hA1B2C3D4, 4'hF, 2'd0, 8'h00},
        vec_t'{1'b0, 20'h00010, 32'h0,        4'hF, 2'd1, 8'h00},
        vec_t'{1'b1, 20'h00010, 32'h11223344, 4'h5, 2'd2, 8'h00},
        vec_t'{1'b0, 20'h00010, 32'h0,        4'hF, 2'd3, 8'h00},
        vec_t'{1'b1, 20'h00014, 32'hCAFEF00D, 4'hF, 2'd1, 8'h03},
        vec_t'{1'b0, 20'h00014, 32'h0,        4'hF, 2'd2, 8'h05},
        vec_t'{1'b0, 20'h00014, 32'h0,        4'hF, 2'd0, 8'h07},
        vec_t'{1'b1, 20'hFFFFC, 32'h5A5A0FF0, 4'hA, 2'd3, 8'h02},
        vec_t'{1'b0, 20'hFFFFC, 32'h0,        4'hF, 2'd1, 8'h06},
        vec_t'{1'b0, 20'h00020, 32'h0,        4'hF, 2'd0, 8'h00},
        vec_t'{1'b1, 20'h00020, 32'h0BADBEEF, 4'h8, 2'd2, 8'h09},
        vec_t'{1'b0, 20'h00020, 32'h0,        4'hF, 2'd0, 8'h01}
    };

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              cpu_req_i = 1'b0;
    logic              cpu_we_i = 1'b0;
    logic [ADDR_W-1:0] cpu_addr_i = '0;
    logic [DATA_W-1:0] cpu_wdata_i = '0;
    logic [BE_W-1:0]   cpu_be_i = '0;
    logic [1:0]        cfg_wait_i = '0;
    logic              mem_busy_i = 1'b0;
    logic              cpu_stall_o;
    logic [DATA_W-1:0] cpu_rdata_o;
    logic              mem_en_o;
    logic              mem_we_o;
    logic [WA_W-1:0]   mem_addr_o;
    logic [DATA_W-1:0] mem_wdata_o;
    logic [BE_W-1:0]   mem_be_o;
    logic [DATA_W-1:0] mem_rdata_i;

    logic [31:0] mem_model [16];
    logic [31:0] shadow    [16];

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #5 clk_i = ~clk_i;

    lmem_wait_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cpu_req_i   (cpu_req_i),
        .cpu_we_i    (cpu_we_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_be_i    (cpu_be_i),
        .cfg_wait_i  (cfg_wait_i),
        .mem_busy_i  (mem_busy_i),
        .cpu_stall_o (cpu_stall_o),
        .cpu_rdata_o (cpu_rdata_o),
        .mem_en_o    (mem_en_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_be_o    (mem_be_o),
        .mem_rdata_i (mem_rdata_i)
    );

    // memory model: asynchronous read, write on the clock edge
    assign mem_rdata_i = mem_model[mem_addr_o[3:0]];

    always @(posedge clk_i) begin
        if (mem_en_o && mem_we_o) begin
            for (int b = 0; b < 4; b++)
                if (mem_be_o[b]) mem_model[mem_addr_o[3:0]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // stall count derived from the requirements (R3, R4)
    function automatic int exp_stalls(input logic [1:0] wt, input logic [7:0] bz);
        int nb = 0;
        for (int c = 0; c < 32; c++) begin
            if (c < 8 && bz[c]) continue;
            if (nb == int'(wt)) return c;
            nb++;
        end
        return -1;
    endfunction

    task automatic run_access(input vec_t v);
        int  cyc = 0;
        bit  fin = 1'b0;
        int  want = exp_stalls(v.wt, v.busy);
        logic [3:0] idx = v.addr[5:2];
        @(negedge clk_i);
        cpu_req_i   = 1'b1;
        cpu_we_i    = v.we;
        cpu_addr_i  = v.addr;
        cpu_wdata_i = v.wdata;
        cpu_be_i    = v.be;
        cfg_wait_i  = v.wt;
        while (!fin && cyc < 40) begin
            mem_busy_i = (cyc < 8) ? v.busy[cyc] : 1'b0;
            #1;
            if (cpu_stall_o) begin
                chk(!mem_en_o && cpu_rdata_o == '0 && mem_be_o == '0, "R6/R8 quiet while stalled",
                    {mem_en_o, 3'b0, mem_be_o, cpu_rdata_o[23:0]}, 32'h0);
                @(negedge clk_i);
                cyc++;
            end else begin
                fin = 1'b1;
            end
        end
        chk(cyc == want, "R3/R4/R5 stall cycles", cyc, want);
        chk(mem_en_o && (mem_we_o == v.we), "R6 strobe at completion", {mem_en_o, mem_we_o}, {1'b1, v.we});
        chk(mem_addr_o == WA_W'(v.addr >> 2), "R9 word address", 32'(mem_addr_o), 32'(v.addr >> 2));
        if (v.we) begin
            chk(mem_be_o == v.be, "R7 byte enables", 32'(mem_be_o), 32'(v.be));
            for (int b = 0; b < 4; b++)
                if (v.be[b]) shadow[idx][8*b +: 8] = v.wdata[8*b +: 8];
        end else begin
            chk(cpu_rdata_o == shadow[idx], "R8 read data", cpu_rdata_o, shadow[idx]);
        end
        @(negedge clk_i);
        cpu_req_i  = 1'b0;
        mem_busy_i = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        int s;
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = '0;
            shadow[i]    = '0;
        end
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        #1;
        chk(!cpu_stall_o && !mem_en_o && cpu_rdata_o == '0 && mem_be_o == '0, "R1 reset state",
            {cpu_stall_o, mem_en_o, 30'(cpu_rdata_o)}, 32'h0);

        for (int k = 0; k < NV; k++) run_access(VECS[k]);

        // R2: no request, busy and wait setting active
        @(negedge clk_i);
        mem_busy_i = 1'b1;
        cfg_wait_i = 2'd3;
        #1;
        chk(!cpu_stall_o && !mem_en_o, "R2 idle ignores busy", {cpu_stall_o, mem_en_o}, 32'h0);
        @(negedge clk_i);
        mem_busy_i = 1'b0;
        #1;
        chk(!cpu_stall_o && !mem_en_o, "R2 idle ignores wait", {cpu_stall_o, mem_en_o}, 32'h0);

        // R10: setting lowered after the count has started
        @(negedge clk_i);
        cpu_req_i  = 1'b1;
        cpu_we_i   = 1'b0;
        cpu_addr_i = 20'h00010;
        cfg_wait_i = 2'd3;
        s = 0;
        #1;
        while (cpu_stall_o && s < 20) begin
            @(negedge clk_i);
            cfg_wait_i = 2'd0;
            s++;
            #1;
        end
        chk(s == 3, "R10 setting captured at start", s, 3);
        chk(cpu_rdata_o == shadow[4], "R10 read data", cpu_rdata_o, shadow[4]);
        @(negedge clk_i);
        cpu_req_i = 1'b0;

        // R11: withdraw during countdown, then a zero-wait request
        @(negedge clk_i);
        cpu_req_i  = 1'b1;
        cfg_wait_i = 2'd3;
        cpu_addr_i = 20'h00014;
        #1;
        chk(cpu_stall_o, "R11 countdown begun", 32'(cpu_stall_o), 32'h1);
        @(negedge clk_i);
        cpu_req_i = 1'b0;
        #1;
        chk(!mem_en_o && !cpu_stall_o, "R11 withdrawn no strobe", {mem_en_o, cpu_stall_o}, 32'h0);
        @(negedge clk_i);
        cpu_req_i  = 1'b1;
        cfg_wait_i = 2'd0;
        #1;
        chk(!cpu_stall_o && mem_en_o, "R11 fresh count", {cpu_stall_o, mem_en_o}, 32'h1);
        chk(cpu_rdata_o == shadow[5], "R11 read data", cpu_rdata_o, shadow[5]);
        @(negedge clk_i);
        cpu_req_i = 1'b0;
        repeat (2) @(negedge clk_i);

        finish_run();
    end

endmodule